// File: doc/BRIEF.md
# I2C EEPROM Target with Page Write Buffer

This block is the target side of a two-wire serial memory. It watches the SCL and SDA lines, recognises start and stop conditions, and answers a select byte that carries a fixed device type, a chip-enable bit and the two upper bits of a 10-bit byte address. The storage is an on-chip array of 1024 bytes. Its contents survive for as long as the block is powered and out of reset.

A write-direction select is followed by a low address byte and then by data bytes. Data bytes go into a 16-byte page buffer. The low four address bits advance after each byte and wrap inside the page. A stop placed exactly in the slot after a data acknowledge starts a timed internal write cycle. That cycle copies the staged bytes into the array. While it runs, the block ignores the bus, so a master can poll with select bytes until it gets an acknowledge. A write-lock input refuses all data bytes.

Reads come in three forms. A random read is a dummy write followed by a repeated start. A current-address read starts from the internal counter. A sequential read continues for as long as the master acknowledges, and the counter wraps across the whole 10-bit space.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. A start always begins a new select byte. Start and stop are both ignored during an internal write cycle.
- R2: SDA is sampled on rising SCL and bytes travel MSB first. The target acknowledges by pulling SDA low during the 9th clock. The target changes its SDA drive only while SCL is low.
- R3: The select byte holds, from MSB to LSB: the type code 1010, a chip bit that must equal `chip_sel_i`, address bits 9 and 8, and the direction bit (1 = read, 0 = write). Any mismatch gets no acknowledge, and the target then ignores every bus bit until the next start.
- R4: After a matching write select, the next byte supplies address bits 7..0. Both the select byte and this address byte are acknowledged, and the internal counter is loaded with the full 10-bit address.
- R5: While `wr_lock_i` is high, each data byte gets a NACK and the memory keeps its contents. While it is low, each data byte is acknowledged.
- R6: Data bytes of one write share address bits 9..4. The low 4 bits step by one per byte and roll from 15 to 0, so a later byte overwrites an earlier one.
- R7: The write cycle starts only when a stop arrives in the slot right after a data byte's acknowledge. A stop inside a byte, or a repeated start, discards the staged bytes and writes nothing.
- R8: The internal write cycle lasts `WRITE_CYCLES` clocks. During it SDA is released and no select byte is acknowledged. The memory changes when the cycle ends.
- R9: After a write cycle, the counter points one past the last written byte, wrapping within the page.
- R10: A random read (write select, address, repeated start, read select) returns the byte stored at that address.
- R11: A read-direction select returns the byte at the counter. Each byte sent advances the counter by one, and 1023 rolls to 0.
- R12: A master ACK after a read byte makes the target send the next byte. A NACK makes it release SDA and ignore the bus until the next start.
- R13: After reset, SDA is released, the counter is 0 and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chip_sel_i | input | 1 | Chip bit the select byte must carry |
| wr_lock_i | input | 1 | 1 refuses data bytes and blocks memory changes |

## Verification
A corrupted protocol state shows on the very next acknowledge slot, as a missing or extra low pulse on `sda_oe`, at most nine SCL periods after the fault. A wrong page pointer or counter stays hidden on the bus until the next read. For that reason each write is followed by a read-back that covers the whole page and the counter's landing point. A write cycle that starts too early, too late or never shows as a wrong poll answer within one select byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DSEL,
    S_DSEL_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK
  } bus_state_t;

  // select byte: type code in [7:4], chip bit in [3]
  function automatic logic sel_matches(input logic [7:0] b, input logic cs);
    return (b[7:4] == DEV_TYPE) && (b[3] == cs);
  endfunction

endpackage

// File: rtl/i2cm_line_watch.sv
module i2cm_line_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_ff[SYNC_STAGES-1];
      sda_d <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[SYNC_STAGES-1];
  assign sda_lvl  = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int         MEM_DEPTH    = 1024,
  parameter int         PAGE_BYTES   = 16,
  parameter int         WRITE_CYCLES = 5000,
  parameter logic [7:0] ERASED       = 8'hFF
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              stage_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]                     stage_idx,
  input  logic [7:0]                                        stage_data,
  input  logic                                              stage_clr,
  input  logic                                              commit_go,
  input  logic [$clog2(MEM_DEPTH)-$clog2(PAGE_BYTES)-1:0]   commit_page,
  input  logic [$clog2(MEM_DEPTH)-1:0]                      rd_addr,
  output logic [7:0]                                        rd_data,
  output logic                                              busy
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = $clog2(MEM_DEPTH) - PAGE_W;
  localparam int TW     = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem [MEM_DEPTH];
  logic [PAGE_BYTES-1:0][7:0] pbuf;
  logic [PAGE_BYTES-1:0] pmask;
  logic [PG_W-1:0]       held_page;
  logic [TW-1:0]         timer;
  logic                  busy_q;
  logic                  cycle_done;

  assign cycle_done = busy_q && (timer == TW'(WRITE_CYCLES - 1));
  assign busy       = busy_q;
  assign rd_data    = mem[rd_addr];

  // one staging slot per page byte
  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [7:0] byte_q;
      logic       vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= '0;
          vld_q  <= 1'b0;
        end else if (cycle_done) begin
          vld_q <= 1'b0;
        end else if (stage_we && stage_idx == PAGE_W'(g)) begin
          byte_q <= stage_data;
          vld_q  <= 1'b1;
        end else if (stage_clr) begin
          vld_q <= 1'b0;
        end
      end
      assign pbuf[g]  = byte_q;
      assign pmask[g] = vld_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      timer     <= '0;
      held_page <= '0;
    end else if (commit_go && !busy_q) begin
      busy_q    <= 1'b1;
      timer     <= '0;
      held_page <= commit_page;
    end else if (cycle_done) begin
      busy_q <= 1'b0;
      timer  <= '0;
    end else if (busy_q) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= ERASED;
    end else if (cycle_done) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{held_page, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  // independent count of busy cycles for the timing check
  logic [TW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_cnt <= '0;
    else if (busy_q) chk_cnt <= chk_cnt + 1'b1;
    else             chk_cnt <= '0;
  end

  AST_WRITE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> chk_cnt == TW'(WRITE_CYCLES)) else $error("write cycle length"); // R8
  AST_NO_STAGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we |-> !busy_q) else $error("staging during write cycle"); // R8
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy_q) else $error("commit while busy"); // R7

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2cm_pkg::*;
#(
  parameter int MEM_DEPTH    = 1024,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic chip_sel_i,
  input  logic wr_lock_i
);

  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int HI_W   = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PAGE_W-1:0] lo_step(input logic [PAGE_W-1:0] l);
    return l + 1'b1;
  endfunction

  // bus events
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  i2cm_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_state_t        st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, tx;
  logic              rw_q, ack_q, slot_q, have_data, mack_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ctr;
  logic [PG_W-1:0]   wpage;
  logic [PAGE_W-1:0] wlo;

  logic              busy;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] addr_in;

  // named internal events
  logic byte_end, live_start, live_stop, stage_we, commit_go, stage_clr;

  assign addr_in    = {hi_q, shreg};
  assign byte_end   = scl_fall && (bitcnt == 4'd8);
  assign live_start = start_ev && !busy;
  assign live_stop  = stop_ev && !busy;
  assign stage_we   = !busy && !start_ev && !stop_ev && (st == S_WDATA) &&
                      byte_end && !wr_lock_i;
  assign commit_go  = live_stop && (st == S_WDATA) && slot_q && have_data;
  assign stage_clr  = (live_start || live_stop) && !commit_go;

  i2cm_store #(
    .MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES), .ERASED(8'hFF)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .stage_we(stage_we), .stage_idx(wlo), .stage_data(shreg),
    .stage_clr(stage_clr), .commit_go(commit_go), .commit_page(wpage),
    .rd_addr(ctr), .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '1;
      rw_q      <= 1'b0;
      ack_q     <= 1'b0;
      slot_q    <= 1'b0;
      have_data <= 1'b0;
      mack_q    <= 1'b0;
      hi_q      <= '0;
      ctr       <= '0;
      wpage     <= '0;
      wlo       <= '0;
    end else if (busy) begin
      st <= S_IDLE;
    end else if (start_ev) begin
      st        <= S_DSEL;
      bitcnt    <= '0;
      slot_q    <= 1'b0;
      have_data <= 1'b0;
    end else if (stop_ev) begin
      st        <= S_IDLE;
      slot_q    <= 1'b0;
      have_data <= 1'b0;
      if (commit_go) ctr <= {wpage, wlo};
    end else begin
      unique case (st)
        S_DSEL, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end
          if (scl_fall) slot_q <= 1'b0;
          if (byte_end) begin
            bitcnt <= '0;
            if (st == S_DSEL) begin
              if (sel_matches(shreg, chip_sel_i)) begin
                rw_q <= shreg[0];
                hi_q <= shreg[HI_W:1];
                st   <= S_DSEL_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_ADDR) begin
              ctr   <= addr_in;
              wpage <= addr_in[ADDR_W-1:PAGE_W];
              wlo   <= addr_in[PAGE_W-1:0];
              st    <= S_ADDR_ACK;
            end else begin
              ack_q <= !wr_lock_i;
              if (!wr_lock_i) begin
                wlo       <= lo_step(wlo);
                have_data <= 1'b1;
              end
              st <= S_WDATA_ACK;
            end
          end
        end
        S_DSEL_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              tx  <= rd_data;
              ctr <= addr_step(ctr);
              st  <= S_RDATA;
            end else begin
              st <= S_ADDR;
            end
          end
        end
        S_ADDR_ACK, S_WDATA_ACK: begin
          if (scl_fall) begin
            st     <= S_WDATA;
            slot_q <= 1'b1;
            bitcnt <= '0;
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            tx     <= {tx[6:0], 1'b1};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              st     <= S_RACK;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack_q <= !sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              tx  <= rd_data;
              ctr <= addr_step(ctr);
              st  <= S_RDATA;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_DSEL_ACK, S_ADDR_ACK: sda_oe = 1'b1;
      S_WDATA_ACK:            sda_oe = ack_q;
      S_RDATA:                sda_oe = !tx[7];
      default:                sda_oe = 1'b0;
    endcase
  end

  AST_DEAF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe) else $error("drive during write cycle"); // R8
  AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_ev || stop_ev) |-> !scl_lvl)
    else $error("SDA drive changed with SCL high"); // R2
  AST_NACK_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA_ACK) && ($past(st) == S_WDATA) && $past(wr_lock_i) |-> !sda_oe)
    else $error("locked data byte acknowledged"); // R5
  AST_LIVE_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_start && live_stop)) else $error("start and stop together"); // R1

endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;

  localparam int WCYC = 400;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic chip_sel = 1'b1;
  logic wr_lock = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .chip_sel_i(chip_sel), .wr_lock_i(wr_lock)
  );

  int errors = 0;
  int checks = 0;
  int edge_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [1024];
  logic [9:0] mctr = '0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  // each vector: {lock, address, data}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 10'h000, 8'h3C}, {1'b0, 10'h3FF, 8'hA5}, {1'b1, 10'h100, 8'h11},
    {1'b0, 10'h2A7, 8'h00}, {1'b1, 10'h000, 8'h77}, {1'b0, 10'h180, 8'hFE}
  };

  // R2: target drive may change only while SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl) edge_viol++;
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b1, a[9:8], rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = !sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl = 1'b1; wt(Q); b = {b[6:0], sda_line}; wt(Q); scl = 1'b0;
    end
    sda_m = !mack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(2); sda_m = 1'b1; wt(Q);
  endtask

  task automatic poll(output bit ack);
    bus_start(); send_byte(sel(10'h0, 1'b0), ack); bus_stop();
  endtask

  task automatic wait_ready();
    bit a;
    for (int i = 0; i < 40; i++) begin
      poll(a);
      if (a) break;
    end
  endtask

  task automatic page_write(input logic [9:0] a, input int n, output bit hdr, output bit dall);
    bit k1, k2, kd;
    bus_start(); send_byte(sel(a, 1'b0), k1); send_byte(a[7:0], k2);
    hdr = k1 && k2; dall = 1'b1;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], kd);
      dall = dall && kd;
    end
    bus_stop();
    if (!wr_lock && n > 0) begin
      for (int k = 0; k < n; k++) model[{a[9:4], 4'(a[3:0] + k)}] = wbuf[k];
      mctr = {a[9:4], 4'(a[3:0] + n)};
    end else begin
      mctr = a;
    end
  endtask

  task automatic rand_read(input logic [9:0] a, input int n);
    bit k;
    bus_start(); send_byte(sel(a, 1'b0), k); send_byte(a[7:0], k);
    bus_start(); send_byte(sel(a, 1'b1), k);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
    mctr = 10'(a + n);
  endtask

  task automatic cur_read(input int n);
    bit k;
    bus_start(); send_byte(sel(10'h0, 1'b1), k);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit hdr, dall, ack;
    logic [9:0] a;
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    wt(5);
    chk(sda_oe == 1'b0, "R13 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0, "R13 released after reset", sda_oe, 0);
    cur_read(1);
    chk(rbuf[0] == 8'hFF, "R13 erased byte at counter 0", rbuf[0], 8'hFF);
    mctr = 10'h001;

    // vector walk: R4 R5 R8 R10
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][17:8];
      wr_lock = VEC[v][18];
      wbuf[0] = VEC[v][7:0];
      page_write(a, 1, hdr, dall);
      chk(hdr, "R4 select and address acked", hdr, 1);
      chk(dall == !VEC[v][18], "R5 data ack follows lock", dall, !VEC[v][18]);
      wr_lock = 1'b0;
      if (!VEC[v][18]) begin
        poll(ack);
        chk(!ack, "R8 poll during write cycle", ack, 0);
        wait_ready();
      end
      rand_read(a, 1);
      chk(rbuf[0] == model[a], "R10 random read", rbuf[0], model[a]);
    end

    // full page then wrapped partial page: R6 R9
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(8'h80 + k);
    page_write(10'h1F0, 16, hdr, dall);
    wait_ready();
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h10 + k);
    page_write(10'h1FC, 6, hdr, dall);
    chk(dall, "R6 six data bytes acked", dall, 1);
    wait_ready();
    cur_read(1);
    chk(rbuf[0] == model[10'h1F2], "R9 counter after write", rbuf[0], model[10'h1F2]);
    rand_read(10'h1F0, 16);
    for (int k = 0; k < 16; k++)
      chk(rbuf[k] == model[10'h1F0 + k], "R6 page roll-over", rbuf[k], model[10'h1F0 + k]);

    // 18 bytes overwrite the first two of the page: R6
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h20 + k);
    page_write(10'h040, 18, hdr, dall);
    wait_ready();
    rand_read(10'h040, 2);
    chk(rbuf[0] == 8'h30, "R6 overwrite idx0", rbuf[0], 8'h30);
    chk(rbuf[1] == 8'h31, "R6 overwrite idx1", rbuf[1], 8'h31);

    // stop inside a data byte: R7
    bus_start(); send_byte(sel(10'h180, 1'b0), ack); send_byte(8'h80, ack);
    send_bits(8'h0F, 4);
    bus_stop();
    poll(ack);
    chk(ack, "R7 no write cycle after mid-byte stop", ack, 1);
    rand_read(10'h180, 1);
    chk(rbuf[0] == model[10'h180], "R7 memory kept", rbuf[0], model[10'h180]);

    // repeated start after a data byte: R7 R1
    bus_start(); send_byte(sel(10'h2A7, 1'b0), ack); send_byte(8'hA7, ack);
    send_byte(8'h99, ack);
    bus_start(); send_byte(sel(10'h2A7, 1'b1), ack);
    chk(ack, "R1 repeated start accepted", ack, 1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    chk(rbuf[0] == model[10'h2A7], "R7 repeated start discards data", rbuf[0], model[10'h2A7]);
    poll(ack);
    chk(ack, "R7 no write cycle after repeated start", ack, 1);

    // select mismatches: R3
    bus_start(); send_byte(8'hA0, ack);
    chk(!ack, "R3 chip bit mismatch", ack, 0);
    send_byte(sel(10'h0, 1'b0), ack);
    chk(!ack, "R3 deaf until next start", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hB8, ack);
    chk(!ack, "R3 type code mismatch", ack, 0);
    bus_stop();

    // sequential read over the top: R11
    rand_read(10'h3FE, 3);
    chk(rbuf[0] == model[10'h3FE], "R11 seq byte 0", rbuf[0], model[10'h3FE]);
    chk(rbuf[1] == model[10'h3FF], "R11 seq byte 1", rbuf[1], model[10'h3FF]);
    chk(rbuf[2] == model[10'h000], "R11 wrap to 0", rbuf[2], model[10'h000]);
    cur_read(1);
    chk(rbuf[0] == model[10'h001], "R11 counter after wrap", rbuf[0], model[10'h001]);

    // NACK then more clocks: R12
    bus_start(); send_byte(sel(10'h0, 1'b1), ack);
    recv_byte(1'b0, rbuf[0]);
    recv_byte(1'b0, rbuf[1]);
    bus_stop();
    chk(rbuf[1] == 8'hFF, "R12 released after master NACK", rbuf[1], 8'hFF);
    cur_read(2);
    chk(rbuf[0] == model[10'h003], "R12 ACK sends next byte", rbuf[0], model[10'h003]);
    chk(rbuf[1] == model[10'h004], "R12 sequential continue", rbuf[1], model[10'h004]);

    chk(edge_viol == 0, "R2 drive changes with SCL low", edge_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule